// File: doc/BRIEF.md
# Receive Word Packer and FIFO

This block sits between a serial receive engine and the bus side of a serial controller. The engine hands over one received byte per strobe. The block gathers the bytes into 32-bit words and stores each complete word as one entry of a FIFO whose depth is a parameter. Every entry is always a whole 32-bit word, whatever the serial word length is.

When the engine signals the end of a transfer, any bytes still held in the packer are stored as a short entry. That entry is right-aligned and tagged with a count of valid bytes. A control word sets the enable, the flush and an interrupt trigger level. The read side shows the head entry and its byte count, and it pops that entry on a read strobe.

Because every entry holds at most four bytes, a receive-only request must ask for no more than four times the depth in bytes, or the FIFO overflows.

Top module: `rxp_top`

## Requirements
- R1: After reset, `fill_o`, `irq_o`, `ovf_o`, `unf_o`, `ctrl_rdata_o`, `rd_data_o` and `rd_nbytes_o` are all zero.
- R2: Four bytes received while enabled form one entry with a byte count of 4. The first byte received lands in bits 31:24 and the last in bits 7:0.
- R3: On `xfer_end_i`, a packer holding 1 to 3 bytes stores an entry that is right-aligned, with zeros above the valid bytes. The earliest byte sits in the highest valid byte, and the count equals the number of bytes. When the byte total is an exact multiple of four, no extra entry is stored.
- R4: A byte strobed in the same cycle as `xfer_end_i` belongs to the closing entry.
- R5: While the enable bit is 0, byte strobes and `xfer_end_i` are ignored. Nothing is stored and the packer contents are unchanged.
- R6: The control word has enable at bit 0, flush at bit 1 and a 6-bit trigger level at bits 13:8. The readback returns enable and trigger at those positions, and bit 1 always reads 0.
- R7: Writing the control word with bit 1 set empties the FIFO and discards a partly packed word at the same clock edge. Bytes strobed in that cycle are discarded too.
- R8: `fill_o` is a 6-bit count of stored entries and never exceeds the depth.
- R9: `irq_o` is high while `fill_o` is nonzero and at or above the trigger level.
- R10: Storing a short entry at the end of a transfer sets a pending interrupt. It holds `irq_o` high until the next successful read or a flush.
- R11: A word stored into a full FIFO, with no read in the same cycle, is dropped. `ovf_o` then pulses high for one cycle after that edge.
- R12: While the FIFO is empty, `rd_data_o` and `rd_nbytes_o` are zero. A read strobe then leaves `fill_o` at 0 and pulses `unf_o` for one cycle after the edge.
- R13: The head entry and its count are visible before the read strobe. `rd_en_i` pops the head so that entries come out in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte |
| xfer_end_i | input | 1 | End of transfer |
| ctrl_wr_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 16 | Control word: bit 0 enable, bit 1 flush, bits 13:8 trigger |
| ctrl_rdata_o | output | 16 | Control word readback |
| rd_en_i | input | 1 | Pop head entry |
| rd_data_o | output | 32 | Head entry data |
| rd_nbytes_o | output | 3 | Valid bytes in head entry (0 when empty) |
| fill_o | output | 6 | Stored entry count |
| irq_o | output | 1 | Receive interrupt |
| ovf_o | output | 1 | Overflow pulse |
| unf_o | output | 1 | Underflow pulse |

## Verification
The bench builds the block with a depth of 4 instead of the default 8. A full FIFO is then reached after sixteen bytes, so a fifth word can be pushed into it and the drop and the overflow pulse can be observed. With a trigger level of 3, the entry counts just below, at and above the level all fit within that short depth. The level interrupt can then be told apart from the pending interrupt that a short entry raises.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = 8 * WORD_BYTES;
  localparam int NB_W       = 3;
  localparam int LVL_W      = 6;
  localparam int CTRL_W     = 16;

  typedef struct packed {
    logic [NB_W-1:0]   nbytes;
    logic [WORD_W-1:0] data;
  } rxp_entry_t;
endpackage

// File: rtl/rxp_rst_sync.sv
module rxp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/rxp_packer.sv
module rxp_packer
  import rxp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       clr,
  input  logic       byte_vld,
  input  logic [7:0] byte_dat,
  input  logic       xfer_end,
  output logic       push_o,
  output logic       partial_o,
  output rxp_entry_t entry_o
);
  logic [WORD_W-1:0] acc_q, acc_d, merged;
  logic [NB_W-1:0]   cnt_q, cnt_d, cnt_sum;
  logic              ld;

  always_comb begin
    merged    = byte_vld ? {acc_q[WORD_W-9:0], byte_dat} : acc_q;
    cnt_sum   = cnt_q + NB_W'(byte_vld);
    acc_d     = acc_q;
    cnt_d     = cnt_q;
    push_o    = 1'b0;
    partial_o = 1'b0;
    entry_o.data   = merged;
    entry_o.nbytes = cnt_sum;
    if (clr) begin
      acc_d = '0;
      cnt_d = '0;
    end else if (en) begin
      if (cnt_sum == NB_W'(WORD_BYTES)) begin
        push_o = 1'b1;
        acc_d  = '0;
        cnt_d  = '0;
      end else if (xfer_end && (cnt_sum != '0)) begin
        push_o    = 1'b1;
        partial_o = 1'b1;
        acc_d     = '0;
        cnt_d     = '0;
      end else begin
        acc_d = merged;
        cnt_d = cnt_sum;
      end
    end
  end

  assign ld = clr | en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (ld) begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/rxp_fifo.sv
module rxp_fifo
  import rxp_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  rxp_entry_t       push_entry,
  input  logic             pop_req,
  output rxp_entry_t       head_o,
  output logic [LVL_W-1:0] count_o,
  output logic             ovf_o,
  output logic             unf_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  rxp_entry_t       mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [LVL_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d, unf_q, unf_d;
  logic             empty, full, pop, push_ok;

  always_comb begin
    empty   = (cnt_q == '0);
    full    = (cnt_q == LVL_W'(DEPTH));
    pop     = pop_req & ~empty & ~flush;
    push_ok = push & (~full | pop) & ~flush;
    ovf_d   = push & full & ~pop & ~flush;
    unf_d   = pop_req & empty & ~flush;
    wptr_d  = wptr_q;
    rptr_d  = rptr_q;
    cnt_d   = cnt_q + LVL_W'(push_ok) - LVL_W'(pop);
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (push_ok) wptr_d = (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
      if (pop)     rptr_d = (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
      ovf_q  <= ovf_d;
      unf_q  <= unf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wptr_q] <= push_entry;
  end

  assign head_o  = empty ? '0 : mem_q[rptr_q];
  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;
  assign unf_o   = unf_q;
endmodule

// File: rtl/rxp_top.sv
module rxp_top
  import rxp_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_vld_i,
  input  logic [7:0]  byte_i,
  input  logic        xfer_end_i,
  input  logic        ctrl_wr_i,
  input  logic [15:0] ctrl_wdata_i,
  output logic [15:0] ctrl_rdata_o,
  input  logic        rd_en_i,
  output logic [31:0] rd_data_o,
  output logic [2:0]  rd_nbytes_o,
  output logic [5:0]  fill_o,
  output logic        irq_o,
  output logic        ovf_o,
  output logic        unf_o
);
  localparam int EN_BIT   = 0;
  localparam int FL_BIT   = 1;
  localparam int TRIG_LSB = 8;

  logic             rst_i_n;
  logic             en_q, en_d, pend_q, pend_d, ctl_ld;
  logic [LVL_W-1:0] trig_q, trig_d, fill;
  logic             flush, pk_push, pk_partial;
  rxp_entry_t       pk_entry, head;

  rxp_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  assign flush = ctrl_wr_i & ctrl_wdata_i[FL_BIT];

  rxp_packer u_pack (
    .clk(clk), .rst_n(rst_i_n), .en(en_q), .clr(flush),
    .byte_vld(byte_vld_i), .byte_dat(byte_i), .xfer_end(xfer_end_i),
    .push_o(pk_push), .partial_o(pk_partial), .entry_o(pk_entry)
  );

  rxp_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_i_n), .flush(flush), .push(pk_push),
    .push_entry(pk_entry), .pop_req(rd_en_i), .head_o(head),
    .count_o(fill), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  always_comb begin
    ctl_ld = ctrl_wr_i;
    en_d   = ctrl_wdata_i[EN_BIT];
    trig_d = ctrl_wdata_i[TRIG_LSB +: LVL_W];
    pend_d = pend_q;
    if (flush)                        pend_d = 1'b0;
    else if (pk_push && pk_partial)   pend_d = 1'b1;
    else if (rd_en_i && fill != '0)   pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      en_q   <= 1'b0;
      trig_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (ctl_ld) begin
        en_q   <= en_d;
        trig_q <= trig_d;
      end
      pend_q <= pend_d;
    end
  end

  assign ctrl_rdata_o = {2'b00, trig_q, 6'b000000, 1'b0, en_q};
  assign rd_data_o    = head.data;
  assign rd_nbytes_o  = head.nbytes;
  assign fill_o       = fill;
  assign irq_o        = pend_q | ((fill != '0) && (fill >= trig_q));
endmodule

// File: rtl/rxp_top_chk.sv
module rxp_top_chk #(
  parameter int DEPTH = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ctrl_wr_i,
  input logic [15:0] ctrl_wdata_i,
  input logic [15:0] ctrl_rdata_o,
  input logic        rd_en_i,
  input logic [31:0] rd_data_o,
  input logic [2:0]  rd_nbytes_o,
  input logic [5:0]  fill_o,
  input logic        irq_o,
  input logic        ovf_o,
  input logic        unf_o
);
  p_fill_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_o <= 6'(DEPTH));

  p_ovf_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> $past(fill_o) == 6'(DEPTH));

  p_unf_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
    unf_o |-> ($past(fill_o) == 6'd0 && fill_o == 6'd0));

  p_empty_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_o == 6'd0) |-> (rd_data_o == 32'd0 && rd_nbytes_o == 3'd0));

  p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_i && ctrl_wdata_i[1]) |=> fill_o == 6'd0);

  p_irq_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_o != 6'd0 && fill_o >= ctrl_rdata_o[13:8]) |-> irq_o);

  p_head_count_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_o != 6'd0) |-> (rd_nbytes_o != 3'd0 && rd_nbytes_o <= 3'd4));

  p_disabled_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_rdata_o[0] && !rd_en_i && !ctrl_wr_i) |=> $stable(fill_o));
endmodule

bind rxp_top rxp_top_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_wr_i(ctrl_wr_i), .ctrl_wdata_i(ctrl_wdata_i),
  .ctrl_rdata_o(ctrl_rdata_o), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
  .rd_nbytes_o(rd_nbytes_o), .fill_o(fill_o), .irq_o(irq_o),
  .ovf_o(ovf_o), .unf_o(unf_o)
);

// File: tb/sim_rxp_top.sv
module sim_rxp_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        byte_vld_i, xfer_end_i, ctrl_wr_i, rd_en_i;
  logic [7:0]  byte_i;
  logic [15:0] ctrl_wdata_i, ctrl_rdata_o;
  logic [31:0] rd_data_o;
  logic [2:0]  rd_nbytes_o;
  logic [5:0]  fill_o;
  logic        irq_o, ovf_o, unf_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [34:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rxp_top #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .xfer_end_i(xfer_end_i), .ctrl_wr_i(ctrl_wr_i), .ctrl_wdata_i(ctrl_wdata_i),
    .ctrl_rdata_o(ctrl_rdata_o), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
    .rd_nbytes_o(rd_nbytes_o), .fill_o(fill_o), .irq_o(irq_o),
    .ovf_o(ovf_o), .unf_o(unf_o)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ctrl_write(input logic [15:0] v);
    ctrl_wr_i = 1'b1; ctrl_wdata_i = v;
    @(negedge clk);
    ctrl_wr_i = 1'b0; ctrl_wdata_i = '0;
  endtask

  // driver: sends n bytes of w (right-aligned, MSB first); queues the expected entry
  task automatic send(input logic [31:0] w, input int n, input bit with_end, input bit store);
    for (int i = 0; i < n; i++) begin
      byte_vld_i = 1'b1;
      byte_i     = w[8*(n-1-i) +: 8];
      xfer_end_i = with_end && (i == n-1);
      @(negedge clk);
    end
    byte_vld_i = 1'b0; xfer_end_i = 1'b0; byte_i = '0;
    if (store) exp_q.push_back({3'(n), w});
  endtask

  // monitor: compares the head against the scoreboard, then pops it
  task automatic read_check(input string tag);
    logic [34:0] e;
    e = (exp_q.size() != 0) ? exp_q.pop_front() : 35'd0;
    check(rd_data_o == e[31:0], {tag, " data"}, 64'(rd_data_o), 64'(e[31:0]));
    check(rd_nbytes_o == e[34:32], {tag, " nbytes"}, 64'(rd_nbytes_o), 64'(e[34:32]));
    rd_en_i = 1'b1;
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; byte_vld_i = 0; xfer_end_i = 0; ctrl_wr_i = 0; rd_en_i = 0;
    byte_i = '0; ctrl_wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(fill_o == 0 && irq_o == 0 && ovf_o == 0 && unf_o == 0, "R1 flags", 64'({fill_o, irq_o, ovf_o, unf_o}), 0);
    check(ctrl_rdata_o == 0 && rd_data_o == 0 && rd_nbytes_o == 0, "R1 data", 64'(ctrl_rdata_o), 0);

    // R6 control layout
    ctrl_write(16'h0301);
    check(ctrl_rdata_o == 16'h0301, "R6 readback", 64'(ctrl_rdata_o), 64'h0301);

    // R2 full word, R8 fill, R13 show-ahead
    send(32'hA1B2C3D4, 4, 0, 1);
    check(fill_o == 1, "R8 fill", 64'(fill_o), 1);
    check(irq_o == 0, "R9 below trigger", 64'(irq_o), 0);
    read_check("R2 R13 word");
    check(fill_o == 0, "R13 popped", 64'(fill_o), 0);

    // R4 byte with end, R10 pending
    send(32'h00112233, 3, 1, 1);
    check(fill_o == 1 && irq_o == 1, "R10 pend set", 64'({fill_o, irq_o}), 64'({6'd1, 1'b1}));
    read_check("R4 partial");
    check(irq_o == 0, "R10 pend cleared", 64'(irq_o), 0);

    // R3 separate end pulse after one byte
    send(32'h0000005A, 1, 0, 0);
    check(fill_o == 0, "R3 held", 64'(fill_o), 0);
    xfer_end_i = 1'b1; @(negedge clk); xfer_end_i = 1'b0;
    exp_q.push_back({3'd1, 32'h0000005A});
    read_check("R3 one byte");

    // R3 exact multiple: no extra entry, no pending
    send(32'hDEADBEEF, 4, 1, 1);
    check(fill_o == 1 && irq_o == 0, "R3 exact multiple", 64'({fill_o, irq_o}), 64'({6'd1, 1'b0}));
    read_check("R3 exact word");

    // R9 level, R11 overflow
    send(32'h01020304, 4, 0, 1);
    send(32'h05060708, 4, 0, 1);
    check(irq_o == 0, "R9 fill 2", 64'(irq_o), 0);
    send(32'h090A0B0C, 4, 0, 1);
    check(irq_o == 1, "R9 fill 3", 64'(irq_o), 1);
    send(32'h0D0E0F10, 4, 0, 1);
    check(fill_o == 4, "R8 full", 64'(fill_o), 4);
    send(32'hFFEEDDCC, 4, 0, 0);
    check(ovf_o == 1 && fill_o == 4, "R11 ovf pulse", 64'({ovf_o, fill_o}), 64'({1'b1, 6'd4}));
    @(negedge clk);
    check(ovf_o == 0, "R11 single pulse", 64'(ovf_o), 0);
    for (int k = 0; k < 4; k++) read_check("R11 R13 order");

    // R12 underflow
    check(rd_data_o == 0 && rd_nbytes_o == 0, "R12 empty head", 64'({rd_nbytes_o, rd_data_o}), 0);
    rd_en_i = 1'b1; @(negedge clk); rd_en_i = 1'b0;
    check(unf_o == 1 && fill_o == 0, "R12 unf pulse", 64'({unf_o, fill_o}), 64'({1'b1, 6'd0}));

    // R5 disabled
    ctrl_write(16'h0300);
    send(32'h00AABBCC, 3, 1, 0);
    check(fill_o == 0 && irq_o == 0, "R5 ignored", 64'({fill_o, irq_o}), 0);
    ctrl_write(16'h0301);
    send(32'h31323334, 4, 0, 1);
    read_check("R5 no leftover");

    // R7 flush
    send(32'h41424344, 4, 0, 0);
    send(32'h51525354, 4, 0, 0);
    send(32'h00006162, 2, 0, 0);
    ctrl_write(16'h0303);
    check(fill_o == 0, "R7 flushed", 64'(fill_o), 0);
    check(ctrl_rdata_o == 16'h0301, "R6 flush reads 0", 64'(ctrl_rdata_o), 64'h0301);
    send(32'h00007172, 2, 1, 1);
    read_check("R7 partial discarded");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule